// File: doc/BRIEF.md
# Strobe-Programmed Mode Register and Address Map Decoder

This block holds a 16-bit mode word that the CPU changes only by touching addresses. It never uses the data byte. A bus write that lands in a 32-byte control window picks one mode bit from the address. The lowest address bit says whether that bit is set or cleared. Because of this, software can change any single bit without a read-modify-write cycle.

The same block decodes every CPU address into one of eight region selects: RAM, three ROM regions, three I/O windows and a boot window. For each access it supplies the offset into the selected region and a translated RAM address. The mode word reshapes this map. It controls an all-RAM map, a high-page remap of the low 32K, and RAM write-through under ROM.

The mode fields are also driven out to the video and memory logic. A rate selector turns the two CPU-rate bits into a clock divide ratio.

Top module: `mode_map_unit`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) clears the whole mode word to zero, so every mode field output is 0, `rate_fast` is 0 and `cpu_div` is `BASE_DIV*4`.
- R2: A strobed write (`bus_strobe`=1, `bus_we`=1) to FFC0–FFDF changes exactly one mode bit, the one indexed by `bus_addr[4:1]`. `bus_addr[0]`=1 sets that bit and 0 clears it. All other bits keep their values.
- R3: The mode word's bit order, from bit 0 up, is: V mode [2:0], display offset [9:3], page bit 10, rate R0 bit 11, rate R1 bit 12, size M0 bit 13, size M1 bit 14, map type bit 15. These appear on `vid_mode`, `disp_base`, `page_hi`, `rate_code`={R1,R0}, `mem_size`={M1,M0} and `all_ram`.
- R4: A mode update becomes visible only after the rising clock edge that ends the write cycle. During the write cycle itself, the outputs and the map still reflect the old word.
- R5: `region_sel` bit 0 (RAM) is selected for 0000–7FFF. When M1=1 and the map type bit is 1, reads of 0000–FEFF select RAM. Otherwise 8000 and above never selects RAM. When RAM is selected, `dev_offset` is 0.
- R6: `ram_addr` equals `bus_addr`, except that when M1=1, the map type bit is 0 and the page bit is 1, `ram_addr[15]` is forced to 1.
- R7: ROM0 (`region_sel` bit 1) covers 8000–9FFF. ROM1 (bit 2) covers A000–BFFF and FFE0–FFFF; both take `dev_offset` = `bus_addr[12:0]`. ROM2 (bit 3) covers C000–FEFF with `dev_offset` = `bus_addr[13:0]`.
- R8: FF00–FF5F selects I/O window 0, 1 or 2 (`region_sel` bits 4, 5, 6) from `bus_addr[6:5]`, with `dev_offset` = `bus_addr[4:0]`. FF60–FFDF selects the boot window (bit 7) with `dev_offset` = address − FF60. This includes a register-update write.
- R9: `ram_we` is high for strobed writes to RAM. With M1=1 and map type 1, it is also high for strobed writes to 8000–FEFF. It stays low for writes at FF00 and above.
- R10: With `rate_code` 00, `rate_fast`=0 and `cpu_div`=`BASE_DIV*4`. With any other code, `rate_fast`=1 and `cpu_div`=`BASE_DIV*2`.
- R11: Without `bus_strobe`, `region_sel` is 0, `ram_we` is 0 and the mode word does not change. A strobed read of the control window does not change the mode word either.
- R12: While `bus_strobe` is high, exactly one bit of `region_sel` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_strobe | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| region_sel | output | 8 | One-hot region: 0 RAM, 1–3 ROM0–2, 4–6 I/O0–2, 7 boot |
| dev_offset | output | 14 | Offset inside the selected non-RAM region |
| ram_addr | output | 16 | Translated RAM address |
| ram_we | output | 1 | RAM write enable, including write-through |
| vid_mode | output | 3 | Video mode field |
| disp_base | output | 7 | Display offset field |
| page_hi | output | 1 | Page select bit |
| rate_code | output | 2 | CPU rate field {R1,R0} |
| mem_size | output | 2 | Memory size field {M1,M0} |
| all_ram | output | 1 | Map type bit |
| rate_fast | output | 1 | Fast CPU rate selected |
| cpu_div | output | DIV_W | CPU clock divide ratio |

## Verification
Some properties are checked on every cycle:
- the one-hot region select, and the silence of the outputs without a strobe;
- the boot select on control writes, and that the addressed bit takes the strobe's value one edge later;
- that a cycle with no update leaves the word untouched;
- that write-through only happens under the all-RAM map, and the forced page bit;
- the agreement between the rate flag and the divide ratio.

The exact region boundaries, the per-region offsets and the old-value-before-the-edge timing can only be shown by the bench's scenarios. The same goes for asynchronous reset in mid-run and reads of the control window being ignored. The bench walks a table of modes and addresses and then runs directed sequences for these cases.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int MODE_W = 16;
  localparam int V_LO   = 0;
  localparam int F_LO   = 3;
  localparam int P1_B   = 10;
  localparam int R0_B   = 11;
  localparam int R1_B   = 12;
  localparam int M0_B   = 13;
  localparam int M1_B   = 14;
  localparam int TY_B   = 15;
  localparam logic [15:0] REG_BASE = 16'hFFC0;

  typedef enum logic [2:0] {
    RG_RAM, RG_ROM0, RG_ROM1, RG_ROM2, RG_IO0, RG_IO1, RG_IO2, RG_BOOT
  } region_e;

  // which region an access falls in
  function automatic region_e region_of(input logic [15:0] a, input logic we,
                                        input logic all_ram);
    if (a < 16'h8000 || (!we && all_ram && a < 16'hFF00)) return RG_RAM;
    if (a < 16'hC000 || a >= 16'hFFE0) return a[13] ? RG_ROM1 : RG_ROM0;
    if (a < 16'hFF00) return RG_ROM2;
    if (a < 16'hFF60) return region_e'(3'd4 + {1'b0, a[6:5]});
    return RG_BOOT;
  endfunction

  // offset inside the selected region
  function automatic logic [13:0] offset_of(input region_e r, input logic [15:0] a);
    case (r)
      RG_ROM0, RG_ROM1:        return {1'b0, a[12:0]};
      RG_ROM2:                 return a[13:0];
      RG_IO0, RG_IO1, RG_IO2:  return {9'd0, a[4:0]};
      RG_BOOT:                 return {7'd0, 7'(a[6:0] - 7'h60)};
      default:                 return '0;
    endcase
  endfunction

  function automatic logic [15:0] ram_xlate(input logic [15:0] a, input logic paged);
    return {a[15] | paged, a[14:0]};
  endfunction

  function automatic logic write_through(input logic [15:0] a, input logic we,
                                         input logic all_ram);
    return we && all_ram && a >= 16'h8000 && a < 16'hFF00;
  endfunction
endpackage

// File: rtl/mmu_mode_reg.sv
module mmu_mode_reg #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [IW-1:0] idx,
  input  logic          val,
  output logic [W-1:0]  q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q[g] <= 1'b0;
      else if (upd && idx == IW'(g))     q[g] <= val;
    end
  end
endmodule

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode
  import mmu_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        strobe,
  input  logic        we,
  input  logic        all_ram,
  input  logic        paged,
  output logic [7:0]  region_sel,
  output logic [13:0] dev_offset,
  output logic [15:0] ram_addr,
  output logic        ram_we
);
  region_e rg;
  assign rg = region_of(addr, we, all_ram);

  always_comb begin
    region_sel = '0;
    dev_offset = '0;
    if (strobe) begin
      region_sel[rg] = 1'b1;
      dev_offset     = offset_of(rg, addr);
    end
  end

  assign ram_addr = ram_xlate(addr, paged);
  assign ram_we   = strobe && we && (rg == RG_RAM || write_through(addr, we, all_ram));
endmodule

// File: rtl/mmu_rate_sel.sv
module mmu_rate_sel #(
  parameter int BASE_DIV = 4,
  localparam int DIV_W = $clog2(BASE_DIV*4 + 1)
) (
  input  logic [1:0]       code,
  output logic             fast,
  output logic [DIV_W-1:0] div
);
  assign fast = |code;
  assign div  = fast ? DIV_W'(BASE_DIV*2) : DIV_W'(BASE_DIV*4);
endmodule

// File: rtl/mode_map_unit.sv
module mode_map_unit
  import mmu_pkg::*;
#(
  parameter int BASE_DIV = 4,
  localparam int DIV_W = $clog2(BASE_DIV*4 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_strobe,
  input  logic             bus_we,
  output logic [7:0]       region_sel,
  output logic [13:0]      dev_offset,
  output logic [15:0]      ram_addr,
  output logic             ram_we,
  output logic [2:0]       vid_mode,
  output logic [6:0]       disp_base,
  output logic             page_hi,
  output logic [1:0]       rate_code,
  output logic [1:0]       mem_size,
  output logic             all_ram,
  output logic             rate_fast,
  output logic [DIV_W-1:0] cpu_div
);
  logic [MODE_W-1:0] mode_q;
  logic              upd_evt;
  logic              map_all_ram;
  logic              map_paged;

  // a write into the control window
  assign upd_evt = bus_strobe && bus_we && (bus_addr[15:5] == REG_BASE[15:5]);

  mmu_mode_reg #(.W(MODE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .upd(upd_evt),
    .idx(bus_addr[4:1]), .val(bus_addr[0]), .q(mode_q)
  );

  assign map_all_ram = mode_q[M1_B] && mode_q[TY_B];
  assign map_paged   = mode_q[M1_B] && !mode_q[TY_B] && mode_q[P1_B];

  mmu_addr_decode u_dec (
    .addr(bus_addr), .strobe(bus_strobe), .we(bus_we),
    .all_ram(map_all_ram), .paged(map_paged),
    .region_sel(region_sel), .dev_offset(dev_offset),
    .ram_addr(ram_addr), .ram_we(ram_we)
  );

  mmu_rate_sel #(.BASE_DIV(BASE_DIV)) u_rate (
    .code(mode_q[R1_B:R0_B]), .fast(rate_fast), .div(cpu_div)
  );

  assign vid_mode  = mode_q[V_LO +: 3];
  assign disp_base = mode_q[F_LO +: 7];
  assign page_hi   = mode_q[P1_B];
  assign rate_code = mode_q[R1_B:R0_B];
  assign mem_size  = mode_q[M1_B:M0_B];
  assign all_ram   = mode_q[TY_B];
endmodule

// File: rtl/mode_map_chk.sv
module mode_map_chk #(
  parameter int BASE_DIV = 4,
  localparam int DIV_W = $clog2(BASE_DIV*4 + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      bus_addr,
  input logic             bus_strobe,
  input logic             bus_we,
  input logic [7:0]       region_sel,
  input logic [15:0]      ram_addr,
  input logic             ram_we,
  input logic [15:0]      mode_q,
  input logic             upd_evt,
  input logic             rate_fast,
  input logic [DIV_W-1:0] cpu_div
);
  // R12
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> $countones(region_sel) == 1);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> (region_sel == 8'd0 && !ram_we));
  // R2
  upd_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> mode_q[$past(bus_addr[4:1])] == $past(bus_addr[0]));
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(mode_q));
  // R8
  upd_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> region_sel[7]);
  // R9
  thru_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !region_sel[0]) |-> (mode_q[15] && mode_q[14] && bus_we));
  // R6
  page_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_sel[0] && mode_q[14] && !mode_q[15] && mode_q[10]) |-> ram_addr[15]);
  // R10
  div_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_div == (rate_fast ? DIV_W'(BASE_DIV*2) : DIV_W'(BASE_DIV*4)));
  // R10
  fast_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_fast == (mode_q[12] || mode_q[11]));
endmodule

bind mode_map_unit mode_map_chk #(.BASE_DIV(BASE_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
  .bus_we(bus_we), .region_sel(region_sel), .ram_addr(ram_addr),
  .ram_we(ram_we), .mode_q(mode_q), .upd_evt(upd_evt),
  .rate_fast(rate_fast), .cpu_div(cpu_div)
);

// File: tb/mode_map_unit_tb.sv
module mode_map_unit_tb_top;
  localparam int BASE_DIV = 4;
  localparam int DIV_W = $clog2(BASE_DIV*4 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_strobe = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] region_sel;
  logic [13:0] dev_offset;
  logic [15:0] ram_addr;
  logic ram_we;
  logic [2:0] vid_mode;
  logic [6:0] disp_base;
  logic page_hi, all_ram, rate_fast;
  logic [1:0] rate_code, mem_size;
  logic [DIV_W-1:0] cpu_div;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mode_map_unit #(.BASE_DIV(BASE_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .bus_we(bus_we), .region_sel(region_sel), .dev_offset(dev_offset),
    .ram_addr(ram_addr), .ram_we(ram_we), .vid_mode(vid_mode),
    .disp_base(disp_base), .page_hi(page_hi), .rate_code(rate_code),
    .mem_size(mem_size), .all_ram(all_ram), .rate_fast(rate_fast),
    .cpu_div(cpu_div)
  );

  typedef struct packed {
    logic [15:0] mode;
    logic [15:0] addr;
    logic        we;
    logic [7:0]  sel;
    logic [13:0] ofs;
    logic [15:0] raddr;
    logic        rwe;
    logic [7:0]  req;
  } vec_t;

  // mode, addr, we, region, offset, ram address, ram write, requirement
  localparam vec_t VECS [25] = '{
    '{16'h0000, 16'h1234, 1'b0, 8'h01, 14'h0000, 16'h1234, 1'b0, 8'd5},  // R5
    '{16'h0000, 16'h7FFF, 1'b1, 8'h01, 14'h0000, 16'h7FFF, 1'b1, 8'd5},
    '{16'h0000, 16'h8000, 1'b0, 8'h02, 14'h0000, 16'h8000, 1'b0, 8'd7},  // R7
    '{16'h0000, 16'h9ABC, 1'b0, 8'h02, 14'h1ABC, 16'h9ABC, 1'b0, 8'd7},
    '{16'h0000, 16'hA123, 1'b0, 8'h04, 14'h0123, 16'hA123, 1'b0, 8'd7},
    '{16'h0000, 16'hFFE5, 1'b0, 8'h04, 14'h1FE5, 16'hFFE5, 1'b0, 8'd7},
    '{16'h0000, 16'hC345, 1'b0, 8'h08, 14'h0345, 16'hC345, 1'b0, 8'd7},
    '{16'h0000, 16'hFEFF, 1'b0, 8'h08, 14'h3EFF, 16'hFEFF, 1'b0, 8'd7},
    '{16'h0000, 16'hFF03, 1'b0, 8'h10, 14'h0003, 16'hFF03, 1'b0, 8'd8},  // R8
    '{16'h0000, 16'hFF3F, 1'b0, 8'h20, 14'h001F, 16'hFF3F, 1'b0, 8'd8},
    '{16'h0000, 16'hFF41, 1'b0, 8'h40, 14'h0001, 16'hFF41, 1'b0, 8'd8},
    '{16'h0000, 16'hFF60, 1'b0, 8'h80, 14'h0000, 16'hFF60, 1'b0, 8'd8},
    '{16'h0000, 16'hFFDF, 1'b0, 8'h80, 14'h007F, 16'hFFDF, 1'b0, 8'd8},
    '{16'hC000, 16'h9000, 1'b0, 8'h01, 14'h0000, 16'h9000, 1'b0, 8'd5},
    '{16'hC000, 16'hFEFF, 1'b0, 8'h01, 14'h0000, 16'hFEFF, 1'b0, 8'd5},
    '{16'hC000, 16'hFF10, 1'b0, 8'h10, 14'h0010, 16'hFF10, 1'b0, 8'd5},
    '{16'h4000, 16'h9000, 1'b0, 8'h02, 14'h1000, 16'h9000, 1'b0, 8'd5},
    '{16'hC000, 16'hC010, 1'b1, 8'h08, 14'h0010, 16'hC010, 1'b1, 8'd9},  // R9
    '{16'hC000, 16'h8001, 1'b1, 8'h02, 14'h0001, 16'h8001, 1'b1, 8'd9},
    '{16'hC000, 16'hFFE0, 1'b1, 8'h04, 14'h1FE0, 16'hFFE0, 1'b0, 8'd9},
    '{16'h0000, 16'hC010, 1'b1, 8'h08, 14'h0010, 16'hC010, 1'b0, 8'd9},
    '{16'h4400, 16'h1234, 1'b0, 8'h01, 14'h0000, 16'h9234, 1'b0, 8'd6},  // R6
    '{16'h4400, 16'h0010, 1'b1, 8'h01, 14'h0000, 16'h8010, 1'b1, 8'd6},
    '{16'h0400, 16'h1234, 1'b0, 8'h01, 14'h0000, 16'h1234, 1'b0, 8'd6},
    '{16'hC400, 16'h1234, 1'b0, 8'h01, 14'h0000, 16'h1234, 1'b0, 8'd6}
  };

  function automatic logic [15:0] word();
    return {all_ram, mem_size, rate_code, page_hi, disp_base, vid_mode};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic stb);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_strobe = stb;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_strobe = 1'b0; bus_we = 1'b0;
  endtask

  task automatic load_mode(input logic [15:0] m);
    for (int i = 0; i < 16; i++)
      access(16'hFFC0 | 16'(i << 1) | {15'd0, m[i]}, 1'b1, 1'b1);
    idle();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", word(), 16'h0000);
    chk("R1", cpu_div, 32'(BASE_DIV*4));
    chk("R1", rate_fast, 0);
    @(negedge clk) rst_n = 1'b1;

    // R3 field layout and R2 read-back
    load_mode(16'hA5C3);
    #1;
    chk("R2", word(), 16'hA5C3);
    chk("R3", vid_mode, 3'b011);
    chk("R3", disp_base, 7'h38);
    chk("R3", page_hi, 1);
    chk("R3", rate_code, 2'b00);
    chk("R3", mem_size, 2'b01);
    chk("R3", all_ram, 1);

    // R2 clear bit 6, set bit 12, others kept
    access(16'hFFCC, 1'b1, 1'b1);
    access(16'hFFD9, 1'b1, 1'b1);
    idle(); #1;
    chk("R2", word(), 16'hB583);

    // R4 old value during write cycle, new after edge; R8 boot select
    access(16'hFFC2, 1'b1, 1'b1); #1;
    chk("R4", word(), 16'hB583);
    chk("R8", region_sel, 8'h80);
    chk("R8", dev_offset, 14'h0062);
    idle(); #1;
    chk("R4", word(), 16'hB581);

    // R11 no strobe, and strobed read of window
    access(16'hFFC5, 1'b1, 1'b0); #1;
    chk("R11", region_sel, 8'h00);
    chk("R11", ram_we, 0);
    access(16'hFFC5, 1'b0, 1'b1); #1;
    chk("R11", region_sel, 8'h80);
    idle(); #1;
    chk("R11", word(), 16'hB581);

    // R10 rate selection
    load_mode(16'h0000);
    access(16'hFFD7, 1'b1, 1'b1); idle(); #1;
    chk("R10", {rate_fast, 27'd0, cpu_div}, {1'b1, 27'd0, DIV_W'(BASE_DIV*2)});
    access(16'hFFD6, 1'b1, 1'b1); access(16'hFFD9, 1'b1, 1'b1); idle(); #1;
    chk("R10", {rate_fast, 27'd0, cpu_div}, {1'b1, 27'd0, DIV_W'(BASE_DIV*2)});
    access(16'hFFD7, 1'b1, 1'b1); idle(); #1;
    chk("R10", {rate_fast, 27'd0, cpu_div}, {1'b1, 27'd0, DIV_W'(BASE_DIV*2)});
    access(16'hFFD6, 1'b1, 1'b1); access(16'hFFD8, 1'b1, 1'b1); idle(); #1;
    chk("R10", {rate_fast, 27'd0, cpu_div}, {1'b0, 27'd0, DIV_W'(BASE_DIV*4)});

    // table walk: R5 R6 R7 R8 R9 R12
    foreach (VECS[k]) begin
      load_mode(VECS[k].mode);
      access(VECS[k].addr, VECS[k].we, 1'b1); #1;
      chk($sformatf("R%0d sel", VECS[k].req), region_sel, VECS[k].sel);
      chk($sformatf("R%0d ofs", VECS[k].req), dev_offset, VECS[k].ofs);
      chk($sformatf("R%0d ram_addr", VECS[k].req), ram_addr, VECS[k].raddr);
      chk($sformatf("R%0d ram_we", VECS[k].req), ram_we, VECS[k].rwe);
      idle();
    end

    // R1 asynchronous reset mid-run
    load_mode(16'hFFFF); #1;
    chk("R1", word(), 16'hFFFF);
    @(negedge clk) rst_n = 1'b0; #1;
    chk("R1", word(), 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule